// File: doc/BRIEF.md
# Two-Level Carry-Lookahead Adder

This block adds two unsigned operands of a parameterised width and an incoming carry. It produces the wrapped sum, the outgoing carry, and a span generate/propagate pair for the whole word. The operands are cut into 4-bit groups. Each group forms one generate and one propagate term for the whole group from its per-bit terms. A second lookahead level turns those group terms and the incoming carry into the carry that enters every group, so no carry ripples from one group to the next.

When there are more than four groups, the second level becomes a tree of 4-wide lookahead units. Each unit reduces up to four neighbours to one span pair, and the carries are fanned back down the tree. The logic is purely combinational.

The span pair lets a wider datapath chain several instances through its own lookahead level. The pair can also be ignored and only the carry output used.

Top module: `cla_adder`

## Requirements
- R1: `sum` equals the low WIDTH bits of `op_a + op_b + carry_in`, with the operands taken as unsigned.
- R2: `carry_out` equals bit WIDTH of the full-width unsigned sum `op_a + op_b + carry_in`.
- R3: `span_prop` is 1 exactly when every bit of `op_a ^ op_b` is 1.
- R4: `span_gen` is 1 exactly when `op_a + op_b` overflows WIDTH bits with the incoming carry taken as 0.
- R5: `carry_out` always equals `span_gen | (span_prop & carry_in)`.
- R6: On a full propagate chain (`op_a ^ op_b` all ones), an incoming carry of 1 gives an all-zero sum and `carry_out` 1. An incoming carry of 0 gives an all-ones sum and `carry_out` 0.
- R7: An all-ones operand plus 1, or plus an incoming carry of 1 with the other operand zero, gives an all-zero sum and `carry_out` 1.
- R8: WIDTH must be a multiple of 4. R1 to R5 hold both at four groups or fewer (a single second-level unit) and at more than four groups (a tree of second-level units).

Some of these can be seen in terms of the two operands. `op_a ^ op_b` is the per-bit propagate term, and `op_a & op_b` is the per-bit generate term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First addend |
| op_b | input | WIDTH | Second addend |
| carry_in | input | 1 | Carry entering bit 0 |
| sum | output | WIDTH | Sum modulo 2^WIDTH |
| carry_out | output | 1 | Carry leaving the top bit |
| span_gen | output | 1 | Whole-word generate term |
| span_prop | output | 1 | Whole-word propagate term |

## Verification
The hardest case to reach from the ports is a carry that is born in the lowest group and has to cross every upper group through their propagate terms, passing through more than one second-level unit. Uniform random operands almost never produce a long all-propagate run. The stimulus therefore builds such operands on purpose. It picks a random propagate mask, forces a chosen run of bits to propagate, and places a single generating bit below that run, at 32 bits where the second level is a two-deep tree. An exhaustive sweep at 8 bits covers every pattern within and between two groups.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Number of lanes one lookahead unit reduces at a time.
    localparam int unsigned LA_LANES = 4;

    // A generate/propagate pair for a bit, a group or a span of groups.
    typedef struct packed {
        logic gen;
        logic prop;
    } gp_t;

    // Reduce the lowest n lanes of v to one span pair, in sum-of-products form.
    function automatic gp_t span_of(input gp_t [LA_LANES-1:0] v, input int n);
        gp_t  r;
        logic term;
        r.gen  = 1'b0;
        r.prop = 1'b1;
        for (int k = 0; k < LA_LANES; k++) begin
            if (k < n) begin
                term = v[k].gen;
                for (int j = k + 1; j < LA_LANES; j++) begin
                    if (j < n) term = term & v[j].prop;
                end
                r.gen  = r.gen | term;
                r.prop = r.prop & v[k].prop;
            end
        end
        return r;
    endfunction

    // Carry entering lane k, expanded over all lower lanes and the incoming carry.
    function automatic logic carry_into(input gp_t [LA_LANES-1:0] v, input int k,
                                        input logic cin);
        logic acc;
        logic term;
        term = cin;
        for (int j = 0; j < LA_LANES; j++) begin
            if (j < k) term = term & v[j].prop;
        end
        acc = term;
        for (int i = 0; i < LA_LANES; i++) begin
            if (i < k) begin
                term = v[i].gen;
                for (int j = i + 1; j < LA_LANES; j++) begin
                    if (j < k) term = term & v[j].prop;
                end
                acc = acc | term;
            end
        end
        return acc;
    endfunction

endpackage

// File: rtl/cla_bit_gp.sv
module cla_bit_gp
    import cla_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output gp_t  [WIDTH-1:0] bit_gp
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign bit_gp[i].gen  = op_a[i] & op_b[i];
        assign bit_gp[i].prop = op_a[i] ^ op_b[i];
    end
endmodule

// File: rtl/cla_span4.sv
module cla_span4
    import cla_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  gp_t [LANES-1:0] lane_gp,
    output gp_t             span_gp
);
    gp_t [LA_LANES-1:0] padded;

    always_comb begin
        padded = '0;
        for (int k = 0; k < int'(LANES); k++) padded[k] = lane_gp[k];
        span_gp = span_of(padded, int'(LANES));
    end
endmodule

// File: rtl/cla_carry4.sv
module cla_carry4
    import cla_pkg::*;
#(
    parameter int unsigned LANES = 4
) (
    input  gp_t  [LANES-1:0] lane_gp,
    input  logic             cin,
    output logic [LANES-1:0] lane_cin
);
    gp_t [LA_LANES-1:0] padded;

    always_comb begin
        padded = '0;
        for (int k = 0; k < int'(LANES); k++) padded[k] = lane_gp[k];
        for (int k = 0; k < int'(LANES); k++) lane_cin[k] = carry_into(padded, k, cin);
    end
endmodule

// File: rtl/cla_tree.sv
module cla_tree
    import cla_pkg::*;
#(
    parameter int unsigned NUM = 8
) (
    input  gp_t  [NUM-1:0] elem_gp,
    input  logic           cin,
    output logic [NUM-1:0] elem_cin,
    output gp_t            span_gp
);
    localparam int unsigned NU = (NUM + LA_LANES - 1) / LA_LANES;

    if (NUM <= LA_LANES) begin : g_leaf
        cla_span4 #(.LANES(NUM)) u_span (
            .lane_gp (elem_gp),
            .span_gp (span_gp)
        );
        cla_carry4 #(.LANES(NUM)) u_carry (
            .lane_gp  (elem_gp),
            .cin      (cin),
            .lane_cin (elem_cin)
        );
    end else begin : g_node
        gp_t  [NU-1:0] unit_gp;
        logic [NU-1:0] unit_cin;

        for (genvar u = 0; u < NU; u++) begin : g_unit
            localparam int unsigned BASE = u * LA_LANES;
            localparam int unsigned L    = (NUM - BASE > LA_LANES) ? LA_LANES : NUM - BASE;

            cla_span4 #(.LANES(L)) u_span (
                .lane_gp (elem_gp[BASE +: L]),
                .span_gp (unit_gp[u])
            );
            cla_carry4 #(.LANES(L)) u_carry (
                .lane_gp  (elem_gp[BASE +: L]),
                .cin      (unit_cin[u]),
                .lane_cin (elem_cin[BASE +: L])
            );
        end

        cla_tree #(.NUM(NU)) u_upper (
            .elem_gp  (unit_gp),
            .cin      (cin),
            .elem_cin (unit_cin),
            .span_gp  (span_gp)
        );
    end
endmodule

// File: rtl/cla_adder.sv
module cla_adder
    import cla_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic             span_gen,
    output logic             span_prop
);
    localparam int unsigned NG = WIDTH / LA_LANES;

    gp_t  [WIDTH-1:0] bit_gp;
    logic [WIDTH-1:0] bit_cin;
    gp_t  [NG-1:0]    grp_gp;
    logic [NG-1:0]    grp_cin;
    gp_t              word_gp;

    cla_bit_gp #(.WIDTH(WIDTH)) u_bits (
        .op_a   (op_a),
        .op_b   (op_b),
        .bit_gp (bit_gp)
    );

    // First level: one span pair per 4-bit group, then the carries inside it.
    for (genvar g = 0; g < NG; g++) begin : g_grp
        cla_span4 #(.LANES(LA_LANES)) u_span (
            .lane_gp (bit_gp[g*LA_LANES +: LA_LANES]),
            .span_gp (grp_gp[g])
        );
        cla_carry4 #(.LANES(LA_LANES)) u_carry (
            .lane_gp  (bit_gp[g*LA_LANES +: LA_LANES]),
            .cin      (grp_cin[g]),
            .lane_cin (bit_cin[g*LA_LANES +: LA_LANES])
        );
    end

    // Second level: carry entering every group, built as a tree when needed.
    cla_tree #(.NUM(NG)) u_second (
        .elem_gp  (grp_gp),
        .cin      (carry_in),
        .elem_cin (grp_cin),
        .span_gp  (word_gp)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_sum
        assign sum[i] = bit_gp[i].prop ^ bit_cin[i];
    end

    assign span_gen  = word_gp.gen;
    assign span_prop = word_gp.prop;
    assign carry_out = word_gp.gen | (word_gp.prop & carry_in);
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
    parameter int unsigned WIDTH = 32
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum,
    input logic             carry_out,
    input logic             span_gen,
    input logic             span_prop
);
    logic [WIDTH:0] ref_full;
    logic [WIDTH:0] ref_nocin;

    always_comb begin
        ref_full  = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
        ref_nocin = {1'b0, op_a} + {1'b0, op_b};
        AST_SUM_MATCH:  assert (sum == ref_full[WIDTH-1:0]);                    // R1
        AST_COUT_MATCH: assert (carry_out == ref_full[WIDTH]);                  // R2
        AST_SPAN_PROP:  assert (span_prop == (&(op_a ^ op_b)));                 // R3
        AST_SPAN_GEN:   assert (span_gen == ref_nocin[WIDTH]);                  // R4
        AST_COUT_SPAN:  assert (carry_out == (span_gen | (span_prop & carry_in))); // R5
    end
endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .op_a      (op_a),
    .op_b      (op_b),
    .carry_in  (carry_in),
    .sum       (sum),
    .carry_out (carry_out),
    .span_gen  (span_gen),
    .span_prop (span_prop)
);

// File: tb/cla_adder_bench.sv
module cla_adder_bench;
    localparam int unsigned W  = 32;
    localparam int unsigned WS = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [W-1:0]  a32, b32, s32;
    logic          c32, co32, sg32, sp32;
    logic [WS-1:0] a8, b8, s8;
    logic          c8, co8, sg8, sp8;

    cla_adder #(.WIDTH(W)) u_cla_adder (
        .op_a (a32), .op_b (b32), .carry_in (c32),
        .sum (s32), .carry_out (co32), .span_gen (sg32), .span_prop (sp32)
    );

    cla_adder #(.WIDTH(WS)) u_cla_adder_w8 (
        .op_a (a8), .op_b (b8), .carry_in (c8),
        .sum (s8), .carry_out (co8), .span_gen (sg8), .span_prop (sp8)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    function automatic logic [W:0] ref32(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic c);
        return {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
    endfunction

    function automatic logic [WS:0] ref8(input logic [WS-1:0] a, input logic [WS-1:0] b,
                                         input logic c);
        return {1'b0, a} + {1'b0, b} + {{WS{1'b0}}, c};
    endfunction

    task automatic run32(input logic [W-1:0] a, input logic [W-1:0] b, input logic c);
        logic [W:0] e;
        logic [W:0] en;
        a32 = a; b32 = b; c32 = c;
        #1;
        e  = ref32(a, b, c);
        en = ref32(a, b, 1'b0);
        check("R1 sum32",  64'(s32),  64'(e[W-1:0]));
        check("R2 cout32", 64'(co32), 64'(e[W]));
        check("R3 prop32", 64'(sp32), 64'(&(a ^ b)));
        check("R4 gen32",  64'(sg32), 64'(en[W]));
        check("R5 relation32", 64'(co32), 64'(en[W] | ((&(a ^ b)) & c)));
    endtask

    initial begin
        a32 = '0; b32 = '0; c32 = 1'b0;
        a8  = '0; b8  = '0; c8  = 1'b0;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Idle state at zero operands
        check("R1 idle sum", 64'(s32), 64'd0);
        check("R2 idle cout", 64'(co32), 64'd0);

        // R7: all-ones plus one, both ways
        run32('1, 32'd1, 1'b0);
        check("R7 ones+1 sum", 64'(s32), 64'd0);
        check("R7 ones+1 cout", 64'(co32), 64'd1);
        run32('1, '0, 1'b1);
        check("R7 ones+cin sum", 64'(s32), 64'd0);
        check("R7 ones+cin cout", 64'(co32), 64'd1);
        run32('1, '1, 1'b1);

        // R6: full propagate chains with a random mask
        for (int n = 0; n < 200; n++) begin
            logic [W-1:0] m;
            m = $urandom();
            run32(m, ~m, 1'b1);
            check("R6 chain cin1 sum", 64'(s32), 64'd0);
            check("R6 chain cin1 cout", 64'(co32), 64'd1);
            run32(m, ~m, 1'b0);
            check("R6 chain cin0 sum", 64'(s32), 64'(32'hFFFF_FFFF));
            check("R6 chain cin0 cout", 64'(co32), 64'd0);
        end

        // R8: one generating bit below a long propagate run across groups
        for (int n = 0; n < 2000; n++) begin
            logic [W-1:0] m;
            logic [W-1:0] a;
            logic [W-1:0] b;
            int pos;
            pos = int'($urandom_range(0, W - 1));
            m = $urandom();
            a = m;
            b = ~m;
            a[pos] = 1'b1;
            b[pos] = 1'b1;
            if ($urandom_range(0, 3) == 0) begin
                int k;
                k = int'($urandom_range(0, W - 1));
                if (k != pos) b[k] = a[k];
            end
            run32(a, b, 1'($urandom_range(0, 1)));
        end

        // Plain random operands at 32 bits
        for (int n = 0; n < 20000; n++) begin
            run32($urandom(), $urandom(), 1'($urandom_range(0, 1)));
        end

        // R8: exhaustive sweep at 8 bits
        for (int ci = 0; ci < 2; ci++) begin
            for (int x = 0; x < 256; x++) begin
                for (int y = 0; y < 256; y++) begin
                    logic [WS:0] e;
                    logic [WS:0] en;
                    a8 = 8'(x); b8 = 8'(y); c8 = 1'(ci);
                    #1;
                    e  = ref8(a8, b8, c8);
                    en = ref8(a8, b8, 1'b0);
                    check("R8 R1 sum8",  64'(s8),  64'(e[WS-1:0]));
                    check("R8 R2 cout8", 64'(co8), 64'(e[WS]));
                    check("R8 R3 prop8", 64'(sp8), 64'(&(a8 ^ b8)));
                    check("R8 R4 gen8",  64'(sg8), 64'(en[WS]));
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #700000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule